// File: doc/BRIEF.md
# Precise Pipeline Exception Controller

This block decides, every cycle, which exceptional event a five-stage in-order pipeline takes, and makes that event precise. The fetch, decode, execute and memory stages each report whether they hold a real instruction, the address that instruction carries, and whether it has faulted, with a cause code. The write-back stage never faults, so it is not an input. An external interrupt request also arrives. It is asynchronous to the core clock, so it passes through a synchronizer first. Once synchronized, it is attached to one chosen stage, the memory stage by default.

Out of all pending events, the block picks the one tied to the oldest instruction, which is the one furthest down the pipeline. The victim and everything younger than it are turned into bubbles through a per-stage flush vector. Fetch is steered to a fixed handler vector. For one cycle the block presents the victim's PC and cause, together with a take strobe, so that a separate control register file can capture them. Every instruction older than the victim drains normally. The victim itself does not complete.

The exception path is combinational from the stage status to the outputs, so the flush lands in the same cycle as the fault it answers. The only state in the block is the synchronizer chain.

Top module: `precise_xcpt_ctrl`

## Requirements
- R1: When no stage holds a valid faulting instruction and no interrupt is taken, `take`, `take_irq` and `fetch_redirect` are low, and `flush` is all zeros.
- R2: Stage index 0 is fetch, 1 is decode, 2 is execute and 3 is memory. When the only valid fault is at stage s, `take` is high and `victim_pc` equals that stage's PC. `cause` equals that stage's code, and `flush[i]` is high exactly for i <= s.
- R3: When several valid stages fault in the same cycle, the one with the highest index wins. It alone sets `victim_pc`, `cause` and the extent of `flush`.
- R4: A stage whose valid bit is low is ignored, whatever its fault bit says. It can neither be taken as an exception nor chosen as the interrupt victim.
- R5: The interrupt request passes through SYNC_DEPTH flip-flops (default 2) before it is acted on. A taken interrupt raises `take` and `take_irq`, and its victim is the stage IRQ_STAGE (default 3). It reports that stage's PC, reports `cause` = IRQ_CAUSE (default 5'h1F), and flushes stages 0 through IRQ_STAGE.
- R6: A valid fault at IRQ_STAGE or any higher stage beats the interrupt, and `take_irq` stays low. The interrupt beats faults at lower stages.
- R7: With `irq_en` low, or with the IRQ_STAGE stage holding a bubble, a synchronized interrupt request is not taken.
- R8: Whenever `take` is high, `fetch_redirect` is high and `redirect_pc` equals HANDLER_VEC (default 32'h0000_0180).
- R9: Synchronous active-high reset clears the synchronizer. While reset is held, and for the first SYNC_DEPTH-1 clock edges after it is released, a held interrupt request is not taken. It is taken after SYNC_DEPTH edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| stg_valid | input | 4 | Per-stage instruction valid, index 0 fetch to 3 memory |
| stg_exc | input | 4 | Per-stage fault raised |
| stg_pc | input | 4*XLEN | Per-stage PC, stage s in bits [s*XLEN +: XLEN] |
| stg_code | input | 4*CAUSE_W | Per-stage cause code, stage s in bits [s*CAUSE_W +: CAUSE_W] |
| irq_raw | input | 1 | Asynchronous interrupt request level |
| irq_en | input | 1 | Interrupt enable, synchronous to clk |
| take | output | 1 | An event is taken this cycle; capture strobe |
| take_irq | output | 1 | The taken event is the interrupt |
| fetch_redirect | output | 1 | Fetch PC select: use `redirect_pc` |
| redirect_pc | output | XLEN | Handler vector address |
| victim_pc | output | XLEN | PC of the victim instruction, zero when idle |
| cause | output | CAUSE_W | Cause code of the taken event, zero when idle |
| flush | output | 4 | Per-stage flush, bit s kills stage s |

## Verification
The checker assumes that the stage status is a set of clean, synchronous levels, with no unknown values outside reset. It also assumes that each stage's PC and code lanes are meaningful only while that stage is valid. The checker relies on `irq_en` being synchronous. It makes no assumption about when `irq_raw` changes. The stimulus changes every input only on the falling edge, and it fills every PC and code lane with a distinct value so that a wrong pick is visible. It holds each pattern for longer than the synchronizer depth, so the interrupt level has settled before any sample is taken.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;
  localparam int NUM_STG = 4;
  localparam int SEL_W   = $clog2(NUM_STG);

  typedef enum logic [SEL_W-1:0] {
    STG_FETCH  = 2'd0,
    STG_DECODE = 2'd1,
    STG_EXEC   = 2'd2,
    STG_MEMORY = 2'd3
  } stage_e;
endpackage

// File: rtl/xcpt_irq_sync.sv
module xcpt_irq_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] chain;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[DEPTH-2:0], d};
      end
    end
  endgenerate

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/xcpt_victim_sel.sv
module xcpt_victim_sel
  import xcpt_pkg::*;
#(
  parameter int IRQ_STAGE = 3
) (
  input  logic [NUM_STG-1:0] valid,
  input  logic [NUM_STG-1:0] exc,
  input  logic               irq_ok,
  output logic               hit,
  output logic               is_irq,
  output logic [SEL_W-1:0]   sel
);
  always_comb begin
    hit    = 1'b0;
    is_irq = 1'b0;
    sel    = '0;
    // Walk from the oldest stage toward fetch; a fault at a stage outranks
    // an interrupt tied to that same stage.
    for (int s = NUM_STG-1; s >= 0; s--) begin
      if (!hit && valid[s] && exc[s]) begin
        hit = 1'b1;
        sel = SEL_W'(s);
      end else if (!hit && s == IRQ_STAGE && valid[s] && irq_ok) begin
        hit    = 1'b1;
        is_irq = 1'b1;
        sel    = SEL_W'(s);
      end
    end
  end
endmodule

// File: rtl/xcpt_flush_gen.sv
module xcpt_flush_gen
  import xcpt_pkg::*;
(
  input  logic               hit,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_STG-1:0] flush
);
  generate
    for (genvar i = 0; i < NUM_STG; i++) begin : g_flush
      assign flush[i] = hit && (SEL_W'(i) <= sel);
    end
  endgenerate
endmodule

// File: rtl/precise_xcpt_ctrl.sv
module precise_xcpt_ctrl
  import xcpt_pkg::*;
#(
  parameter int               XLEN       = 32,
  parameter int               CAUSE_W    = 5,
  parameter int               SYNC_DEPTH = 2,
  parameter int               IRQ_STAGE  = 3,
  parameter logic [4:0]       IRQ_CAUSE  = 5'h1F,
  parameter logic [31:0]      HANDLER_VEC = 32'h0000_0180
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_STG-1:0]         stg_valid,
  input  logic [NUM_STG-1:0]         stg_exc,
  input  logic [NUM_STG*XLEN-1:0]    stg_pc,
  input  logic [NUM_STG*CAUSE_W-1:0] stg_code,
  input  logic                       irq_raw,
  input  logic                       irq_en,
  output logic                       take,
  output logic                       take_irq,
  output logic                       fetch_redirect,
  output logic [XLEN-1:0]            redirect_pc,
  output logic [XLEN-1:0]            victim_pc,
  output logic [CAUSE_W-1:0]         cause,
  output logic [NUM_STG-1:0]         flush
);
  logic             irq_sync;
  logic             hit;
  logic             is_irq;
  logic [SEL_W-1:0] sel;

  xcpt_irq_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_raw),
    .q   (irq_sync)
  );

  xcpt_victim_sel #(.IRQ_STAGE(IRQ_STAGE)) u_sel (
    .valid  (stg_valid),
    .exc    (stg_exc),
    .irq_ok (irq_sync & irq_en),
    .hit    (hit),
    .is_irq (is_irq),
    .sel    (sel)
  );

  xcpt_flush_gen u_flush (
    .hit   (hit),
    .sel   (sel),
    .flush (flush)
  );

  assign take           = hit;
  assign take_irq       = is_irq;
  assign fetch_redirect = hit;
  assign redirect_pc    = XLEN'(HANDLER_VEC);

  always_comb begin
    victim_pc = '0;
    cause     = '0;
    if (hit) begin
      victim_pc = stg_pc[sel*XLEN +: XLEN];
      cause     = is_irq ? CAUSE_W'(IRQ_CAUSE) : stg_code[sel*CAUSE_W +: CAUSE_W];
    end
  end
endmodule

// File: rtl/precise_xcpt_ctrl_chk.sv
module precise_xcpt_ctrl_chk
  import xcpt_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          CAUSE_W     = 5,
  parameter int          IRQ_STAGE   = 3,
  parameter logic [4:0]  IRQ_CAUSE   = 5'h1F,
  parameter logic [31:0] HANDLER_VEC = 32'h0000_0180
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_STG-1:0]         stg_valid,
  input logic [NUM_STG-1:0]         stg_exc,
  input logic [NUM_STG*XLEN-1:0]    stg_pc,
  input logic [NUM_STG*CAUSE_W-1:0] stg_code,
  input logic                       irq_en,
  input logic                       take,
  input logic                       take_irq,
  input logic                       fetch_redirect,
  input logic [XLEN-1:0]            redirect_pc,
  input logic [XLEN-1:0]            victim_pc,
  input logic [CAUSE_W-1:0]         cause,
  input logic [NUM_STG-1:0]         flush
);
  localparam int TOP = NUM_STG-1;

  a_r1_idle_no_flush: assert property (@(posedge clk) disable iff (rst)
    !take |-> (flush == '0 && !take_irq));

  a_r2_fetch_always_killed: assert property (@(posedge clk) disable iff (rst)
    take |-> flush[0]);

  a_r3_oldest_wins: assert property (@(posedge clk) disable iff (rst)
    (stg_valid[TOP] && stg_exc[TOP]) |->
      (take && !take_irq && flush == '1 &&
       victim_pc == stg_pc[TOP*XLEN +: XLEN] &&
       cause == stg_code[TOP*CAUSE_W +: CAUSE_W]));

  a_r4_all_bubbles: assert property (@(posedge clk) disable iff (rst)
    (stg_valid == '0) |-> !take);

  a_r5_irq_victim: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> (stg_valid[IRQ_STAGE] &&
                  victim_pc == stg_pc[IRQ_STAGE*XLEN +: XLEN] &&
                  cause == CAUSE_W'(IRQ_CAUSE)));

  a_r7_irq_masked: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !take_irq);

  a_r8_handler_vector: assert property (@(posedge clk) disable iff (rst)
    fetch_redirect |-> (take && redirect_pc == XLEN'(HANDLER_VEC)));
endmodule

bind precise_xcpt_ctrl precise_xcpt_ctrl_chk #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .IRQ_STAGE(IRQ_STAGE),
  .IRQ_CAUSE(IRQ_CAUSE), .HANDLER_VEC(HANDLER_VEC)
) u_chk (.*);

// File: tb/precise_xcpt_ctrl_test.sv
`timescale 1ns/1ps
module precise_xcpt_ctrl_test;
  localparam int XLEN = 32;
  localparam int CW   = 5;
  localparam int NS   = 4;
  localparam logic [CW-1:0]   IRQC = 5'h1F;
  localparam logic [XLEN-1:0] HVEC = 32'h0000_0180;

  // {valid[4], exc[4], irq, en, exp_take, exp_irq, exp_flush[4], exp_sel[2]}
  localparam int NV = 15;
  localparam logic [17:0] VEC [NV] = '{
    {4'hF, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 2'd0},
    {4'hF, 4'h1, 1'b0, 1'b1, 1'b1, 1'b0, 4'h1, 2'd0},
    {4'hF, 4'h2, 1'b0, 1'b1, 1'b1, 1'b0, 4'h3, 2'd1},
    {4'hF, 4'h4, 1'b0, 1'b1, 1'b1, 1'b0, 4'h7, 2'd2},
    {4'hF, 4'h8, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 2'd3},
    {4'hF, 4'hF, 1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 2'd3},
    {4'hF, 4'h6, 1'b0, 1'b1, 1'b1, 1'b0, 4'h7, 2'd2},
    {4'hB, 4'h4, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 2'd0},
    {4'hB, 4'h5, 1'b0, 1'b1, 1'b1, 1'b0, 4'h1, 2'd0},
    {4'hF, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 2'd3},
    {4'hF, 4'h6, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 2'd3},
    {4'hF, 4'h8, 1'b1, 1'b1, 1'b1, 1'b0, 4'hF, 2'd3},
    {4'hF, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 2'd0},
    {4'h7, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 2'd0},
    {4'h7, 4'h2, 1'b1, 1'b1, 1'b1, 1'b0, 4'h3, 2'd1}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NS-1:0]     stg_valid = '0;
  logic [NS-1:0]     stg_exc = '0;
  logic [NS*XLEN-1:0] stg_pc;
  logic [NS*CW-1:0]  stg_code;
  logic              irq_raw = 1'b0;
  logic              irq_en = 1'b0;
  logic              take, take_irq, fetch_redirect;
  logic [XLEN-1:0]   redirect_pc, victim_pc;
  logic [CW-1:0]     cause;
  logic [NS-1:0]     flush;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  precise_xcpt_ctrl uut (
    .clk(clk), .rst(rst), .stg_valid(stg_valid), .stg_exc(stg_exc),
    .stg_pc(stg_pc), .stg_code(stg_code), .irq_raw(irq_raw), .irq_en(irq_en),
    .take(take), .take_irq(take_irq), .fetch_redirect(fetch_redirect),
    .redirect_pc(redirect_pc), .victim_pc(victim_pc), .cause(cause), .flush(flush)
  );

  function automatic logic [XLEN-1:0] pc_of(int s);
    return 32'h4000_0000 + 32'(s) * 32'h10;
  endfunction

  function automatic string tag_of(int i);
    case (i)
      0: return "R1";
      1, 2, 3, 4: return "R2";
      5, 6: return "R3";
      7, 8: return "R4";
      9: return "R5";
      10, 11: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      stg_pc[s*XLEN +: XLEN] = pc_of(s);
      stg_code[s*CW +: CW]   = CW'(s + 1);
    end
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    // R9: interrupt held through reset is not seen until the chain fills
    stg_valid = 4'hF;
    irq_raw   = 1'b1;
    irq_en    = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(take_irq == 1'b0, "R9", "take_irq in reset", 32'(take_irq), 32'd0);
    check(take == 1'b0, "R1", "take idle in reset", 32'(take), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(take_irq == 1'b0, "R9", "take_irq one edge after reset", 32'(take_irq), 32'd0);
    @(negedge clk);
    check(take_irq == 1'b1, "R9", "take_irq two edges after reset", 32'(take_irq), 32'd1);
    check(victim_pc == pc_of(3), "R5", "irq victim pc", victim_pc, pc_of(3));
    irq_raw = 1'b0;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      string t;
      int sel;
      v = VEC[i];
      t = tag_of(i);
      sel = int'(v[1:0]);
      stg_valid = v[17:14];
      stg_exc   = v[13:10];
      irq_raw   = v[9];
      irq_en    = v[8];
      repeat (3) @(negedge clk);
      check(take == v[7], t, $sformatf("take vec%0d", i), 32'(take), 32'(v[7]));
      check(take_irq == v[6], t, $sformatf("take_irq vec%0d", i), 32'(take_irq), 32'(v[6]));
      check(flush == v[5:2], t, $sformatf("flush vec%0d", i), 32'(flush), 32'(v[5:2]));
      if (v[7]) begin
        logic [CW-1:0] ec;
        ec = v[6] ? IRQC : CW'(sel + 1);
        check(victim_pc == pc_of(sel), t, $sformatf("victim_pc vec%0d", i), victim_pc, pc_of(sel));
        check(cause == ec, t, $sformatf("cause vec%0d", i), 32'(cause), 32'(ec));
        check(fetch_redirect && redirect_pc == HVEC, "R8", $sformatf("redirect vec%0d", i),
              redirect_pc, HVEC);
      end else begin
        check(!fetch_redirect, "R1", $sformatf("no redirect vec%0d", i), 32'(fetch_redirect), 32'd0);
      end
    end

    // R4 corner: all bubbles with every fault bit set, interrupt pending
    stg_valid = 4'h0;
    stg_exc   = 4'hF;
    irq_raw   = 1'b1;
    irq_en    = 1'b1;
    repeat (3) @(negedge clk);
    check(take == 1'b0, "R4", "all bubbles take", 32'(take), 32'd0);
    check(flush == 4'h0, "R4", "all bubbles flush", 32'(flush), 32'd0);

    // R6 corner: interrupt against fetch-only fault, MEM valid
    stg_valid = 4'hF;
    stg_exc   = 4'h1;
    @(negedge clk);
    check(take_irq == 1'b1, "R6", "irq beats fetch fault", 32'(take_irq), 32'd1);
    check(cause == IRQC, "R5", "irq cause", 32'(cause), 32'(IRQC));

    // R9: reset mid-run clears the synchronizer immediately
    rst = 1'b1;
    @(negedge clk);
    check(take_irq == 1'b0, "R9", "irq cleared by reset", 32'(take_irq), 32'd0);
    rst = 1'b0;
    irq_raw = 1'b0;
    stg_exc = 4'h0;
    repeat (3) @(negedge clk);
    check(take == 1'b0, "R1", "quiet after reset", 32'(take), 32'd0);

    finish_run();
  end
endmodule